// File: doc/BRIEF.md
# Synchronous CPU Bus Master Interface

This block sits between a processor core and a shared, clocked system bus. The core hands it one read or write request at a time. The block runs that request on the bus: it presents the address and the transfer direction with an address-valid strobe, then holds them until the addressed memory or device pulls the active-low ready line. It then finishes the transfer and reports completion to the core. For a read it also returns the data captured from the bus. A write drives the bus data lines only in the cycles in which the target may take the data. An output-enable marks those cycles and stands in for a three-state pad driver.

The processor owns the bus by default. Another agent can borrow the whole bus through a separate four-phase request/grant pair. The agent raises its request, the block raises the grant, the agent lowers its request, and the block lowers the grant. A grant is only issued between transfers, so a transfer that has started always runs to its end. A core request that is waiting while the bus is lent out stays latched and runs once the bus comes back.

Top module: `cpubus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, the address strobe, data output-enable, grant and completion outputs are 0 and the request-ready output is 1.
- R2: A core request is taken at a clock edge where request-valid and request-ready are both 1. Request-ready is then 0 until the transfer completes. A request-valid seen while ready is 0 is ignored and never reaches the bus.
- R3: Unless the bus is lent out, the transfer's address phase appears in the cycle after the request is taken. The address strobe is 1 and the address output equals the taken address. The direction output is 1 for a read and 0 for a write. Strobe, address and direction stay unchanged until completion.
- R4: Ready is only sampled in wait cycles, and every transfer has at least one. A ready low during the address phase has no effect, and the transfer stays in wait while ready is high.
- R5: A ready low in a wait cycle makes the completion output 1 in the next cycle, for exactly that one cycle. For a read, the read-data output then equals the bus data sampled at that edge and holds it until the next read completes.
- R6: The data output-enable is 1 only in wait cycles of a write, with the bus data output equal to the write data taken. It is never 1 for a read or in the address phase.
- R7: An agent request seen while idle raises the grant in the next cycle. The grant stays high while the request stays high and falls one cycle after the request falls. While granted, the address strobe and output-enable are 0.
- R8: An agent request that arrives during a transfer is not granted until that transfer has completed and the block has passed one idle cycle.
- R9: If an agent request and a waiting core request meet in the same idle cycle, the agent is granted first. The core request stays latched and starts its address phase in the cycle after the grant falls.
- R10: A core request taken while the bus is lent out does not start until the grant has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock shared by all agents |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Core presents a request |
| cpu_req_write | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | ADDR_W | Request address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Block can take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Last captured read data |
| bus_addr | output | ADDR_W | Address bundle |
| bus_addr_en | output | 1 | Address-valid strobe |
| bus_rd_wrn | output | 1 | Direction, 1 read / 0 write |
| bus_wdata | output | DATA_W | Data driven onto the bus |
| bus_data_oe | output | 1 | Data driver enable |
| bus_rdata | input | DATA_W | Data seen on the bus |
| bus_ready_n | input | 1 | Active-low transfer ready from target |
| dev_bus_req | input | 1 | Other agent asks for the bus |
| dev_bus_grant | output | 1 | Bus lent to the other agent |

## Verification
An agent's request for the bus can meet a core transfer in the same cycle, and the bench sets up both orders. In the first order, the agent request rises while a read is held in wait. The bench checks that the grant stays low through completion and the following idle cycle, and rises only after that. In the second order, a core request and an agent request are raised in the same cycle while idle. The bench checks that the grant comes first with the bus quiet, and that the core's address phase appears in the cycle after the grant drops, carrying the original address.

// File: rtl/cpubus_pkg.sv
package cpubus_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_ADDR = 3'd1,
        SEQ_WAIT = 3'd2,
        SEQ_DONE = 3'd3,
        SEQ_LENT = 3'd4
    } seq_state_e;

    function automatic logic owns_addr(input seq_state_e s);
        return (s == SEQ_ADDR) || (s == SEQ_WAIT);
    endfunction

    function automatic logic drives_data(input seq_state_e s, input logic wr);
        return (s == SEQ_WAIT) && wr;
    endfunction

endpackage

// File: rtl/cpubus_req_latch.sv
module cpubus_req_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              release_i,
    output logic              hold_valid,
    output logic              hold_write,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata
);
    logic take;
    assign take = in_valid && !hold_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_write <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if (release_i) begin
            hold_valid <= 1'b0;
        end else if (take) begin
            hold_valid <= 1'b1;
            hold_write <= in_write;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/cpubus_seq.sv
module cpubus_seq
    import cpubus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pending,
    input  logic              is_write,
    input  logic              dev_req,
    input  logic              ready_n,
    input  logic [DATA_W-1:0] bus_rdata,
    output seq_state_e        state,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE: begin
                if (dev_req)      nxt = SEQ_LENT;
                else if (pending) nxt = SEQ_ADDR;
            end
            SEQ_ADDR: nxt = SEQ_WAIT;
            SEQ_WAIT: if (!ready_n) nxt = SEQ_DONE;
            SEQ_DONE: nxt = SEQ_IDLE;
            SEQ_LENT: if (!dev_req) nxt = SEQ_IDLE;
            default:  nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            rdata <= '0;
        end else begin
            state <= nxt;
            if (state == SEQ_WAIT && !ready_n && !is_write)
                rdata <= bus_rdata;
        end
    end

    assign done = (state == SEQ_DONE);
endmodule

// File: rtl/cpubus_drive.sv
module cpubus_drive
    import cpubus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  seq_state_e        state,
    input  logic              hold_write,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [DATA_W-1:0] hold_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_en,
    output logic              bus_rd_wrn,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe,
    output logic              grant
);
    always_comb begin
        bus_addr_en = owns_addr(state);
        bus_data_oe = drives_data(state, hold_write);
        bus_addr    = bus_addr_en ? hold_addr : '0;
        bus_rd_wrn  = bus_addr_en ? !hold_write : 1'b1;
        bus_wdata   = bus_data_oe ? hold_wdata : '0;
        grant       = (state == SEQ_LENT);
    end
endmodule

// File: rtl/cpubus_master.sv
module cpubus_master
    import cpubus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_en,
    output logic              bus_rd_wrn,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready_n,
    input  logic              dev_bus_req,
    output logic              dev_bus_grant
);
    seq_state_e        state;
    logic              hold_valid;
    logic              hold_write;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;

    cpubus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (cpu_req_valid),
        .in_write   (cpu_req_write),
        .in_addr    (cpu_req_addr),
        .in_wdata   (cpu_req_wdata),
        .release_i  (cpu_done),
        .hold_valid (hold_valid),
        .hold_write (hold_write),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata)
    );

    cpubus_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pending   (hold_valid),
        .is_write  (hold_write),
        .dev_req   (dev_bus_req),
        .ready_n   (bus_ready_n),
        .bus_rdata (bus_rdata),
        .state     (state),
        .rdata     (cpu_rdata),
        .done      (cpu_done)
    );

    cpubus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .state       (state),
        .hold_write  (hold_write),
        .hold_addr   (hold_addr),
        .hold_wdata  (hold_wdata),
        .bus_addr    (bus_addr),
        .bus_addr_en (bus_addr_en),
        .bus_rd_wrn  (bus_rd_wrn),
        .bus_wdata   (bus_wdata),
        .bus_data_oe (bus_data_oe),
        .grant       (dev_bus_grant)
    );

    assign cpu_req_ready = !hold_valid;
endmodule

// File: rtl/cpubus_master_chk.sv
module cpubus_master_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_ready,
    input logic              cpu_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_addr_en,
    input logic              bus_rd_wrn,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_data_oe,
    input logic              bus_ready_n,
    input logic              dev_bus_req,
    input logic              dev_bus_grant
);
    // R2: no new request is taken while one is outstanding
    a_r2_ready_low_until_done: assert property (@(posedge clk) disable iff (rst)
        (!cpu_req_ready && !cpu_done) |=> !cpu_req_ready);

    // R3: address and direction stay still across the strobe window
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_en && $past(bus_addr_en)) |-> ($stable(bus_addr) && $stable(bus_rd_wrn)));

    // R4: the cycle after the address phase is never a completion
    a_r4_min_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_addr_en) |=> !cpu_done);

    // R5: completion follows a sampled low ready and lasts one cycle
    a_r5_done_after_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_done) |-> $past(bus_addr_en && !bus_ready_n));
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    // R6: data is only driven for a write with the address valid
    a_r6_oe_write_only: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> (bus_addr_en && !bus_rd_wrn));
    a_r6_wdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !bus_data_oe |-> (bus_wdata == '0));

    // R7: lent bus is quiet, and the grant follows the request down
    a_r7_lent_quiet: assert property (@(posedge clk) disable iff (rst)
        dev_bus_grant |-> (!bus_addr_en && !bus_data_oe));
    a_r7_grant_release: assert property (@(posedge clk) disable iff (rst)
        (dev_bus_grant && !dev_bus_req) |=> !dev_bus_grant);

    // R8: a grant never starts straight out of a transfer
    a_r8_grant_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_bus_grant) |-> $past(!bus_addr_en && !cpu_done && dev_bus_req));
endmodule

bind cpubus_master cpubus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_ready (cpu_req_ready),
    .cpu_done      (cpu_done),
    .bus_addr      (bus_addr),
    .bus_addr_en   (bus_addr_en),
    .bus_rd_wrn    (bus_rd_wrn),
    .bus_wdata     (bus_wdata),
    .bus_data_oe   (bus_data_oe),
    .bus_ready_n   (bus_ready_n),
    .dev_bus_req   (dev_bus_req),
    .dev_bus_grant (dev_bus_grant)
);

// File: tb/tb_cpubus_master.sv
module tb_cpubus_master;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready;
    logic          cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_en;
    logic          bus_rd_wrn;
    logic [DW-1:0] bus_wdata;
    logic          bus_data_oe;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready_n = 1'b1;
    logic          dev_bus_req = 1'b0;
    logic          dev_bus_grant;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    always #5 clk = ~clk;

    cpubus_master #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(bus_addr_en == 0, "R1 addr_en", bus_addr_en, 0);
        chk(bus_data_oe == 0, "R1 oe", bus_data_oe, 0);
        chk(dev_bus_grant == 0, "R1 grant", dev_bus_grant, 0);
        chk(cpu_done == 0, "R1 done", cpu_done, 0);
        chk(cpu_req_ready == 1, "R1 ready", cpu_req_ready, 1);
    endtask

    task automatic t_read();
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 16'h1234;
        step();
        cpu_req_valid = 0;
        chk(cpu_req_ready == 0, "R2 ready low", cpu_req_ready, 0);
        step();
        chk(bus_addr_en == 1, "R3 strobe", bus_addr_en, 1);
        chk(bus_addr == 16'h1234, "R3 addr", bus_addr, 16'h1234);
        chk(bus_rd_wrn == 1, "R3 read dir", bus_rd_wrn, 1);
        chk(bus_data_oe == 0, "R6 read no oe", bus_data_oe, 0);
        bus_ready_n = 0;                        // R4: ignored in address phase
        step();
        bus_ready_n = 1;
        chk(cpu_done == 0, "R4 addr-phase ready ignored", cpu_done, 0);
        chk(bus_addr_en == 1, "R4 in wait", bus_addr_en, 1);
        step();
        chk(cpu_done == 0, "R4 holds while ready high", cpu_done, 0);
        chk(bus_data_oe == 0, "R6 read wait no oe", bus_data_oe, 0);
        bus_ready_n = 0; bus_rdata = 32'hCAFE_F00D;
        step();
        bus_ready_n = 1; bus_rdata = 32'h0BAD_0BAD;
        chk(cpu_done == 1, "R5 done", cpu_done, 1);
        chk(cpu_rdata == 32'hCAFE_F00D, "R5 rdata", cpu_rdata, 32'hCAFE_F00D);
        step();
        chk(cpu_done == 0, "R5 done one cycle", cpu_done, 0);
        chk(cpu_rdata == 32'hCAFE_F00D, "R5 rdata held", cpu_rdata, 32'hCAFE_F00D);
        chk(cpu_req_ready == 1, "R2 ready back", cpu_req_ready, 1);
    endtask

    task automatic t_write();
        cpu_req_valid = 1; cpu_req_write = 1; cpu_req_addr = 16'h00A5; cpu_req_wdata = 32'h1357_9BDF;
        step();
        cpu_req_write = 0; cpu_req_addr = 16'h7777; cpu_req_wdata = 32'h2222_2222; // R2: ignored
        step();
        cpu_req_valid = 0;
        chk(bus_addr == 16'h00A5, "R2 second request ignored", bus_addr, 16'h00A5);
        chk(bus_rd_wrn == 0, "R3 write dir", bus_rd_wrn, 0);
        chk(bus_data_oe == 0, "R6 no oe in addr phase", bus_data_oe, 0);
        step();
        chk(bus_data_oe == 1, "R6 oe in write wait", bus_data_oe, 1);
        chk(bus_wdata == 32'h1357_9BDF, "R6 wdata", bus_wdata, 32'h1357_9BDF);
        bus_ready_n = 0;
        step();
        bus_ready_n = 1;
        chk(cpu_done == 1, "R5 write done", cpu_done, 1);
        chk(bus_data_oe == 0, "R6 oe off at done", bus_data_oe, 0);
        step();
        step();
        chk(bus_addr_en == 0, "R2 ignored request never runs", bus_addr_en, 0);
    endtask

    task automatic t_grant();
        dev_bus_req = 1;
        step();
        chk(dev_bus_grant == 1, "R7 grant", dev_bus_grant, 1);
        chk(bus_addr_en == 0, "R7 quiet", bus_addr_en, 0);
        step();
        chk(dev_bus_grant == 1, "R7 grant held", dev_bus_grant, 1);
        dev_bus_req = 0;
        step();
        chk(dev_bus_grant == 0, "R7 grant drop", dev_bus_grant, 0);
    endtask

    task automatic t_req_mid_transfer();
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 16'h0F0F;
        step(); cpu_req_valid = 0;
        step(); step();                         // now in wait
        dev_bus_req = 1;
        step();
        chk(dev_bus_grant == 0, "R8 no grant in wait", dev_bus_grant, 0);
        bus_ready_n = 0; bus_rdata = 32'h5555_AAAA;
        step();
        bus_ready_n = 1;
        chk(dev_bus_grant == 0, "R8 no grant at done", dev_bus_grant, 0);
        step();
        chk(dev_bus_grant == 0, "R8 idle cycle first", dev_bus_grant, 0);
        step();
        chk(dev_bus_grant == 1, "R8 grant after idle", dev_bus_grant, 1);
        dev_bus_req = 0;
        step();
    endtask

    task automatic t_same_cycle();
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 16'hBEEF; dev_bus_req = 1;
        step(); cpu_req_valid = 0;
        step();
        chk(dev_bus_grant == 1, "R9 agent first", dev_bus_grant, 1);
        chk(bus_addr_en == 0, "R9 cpu waits", bus_addr_en, 0);
        chk(cpu_req_ready == 0, "R9 cpu latched", cpu_req_ready, 0);
        dev_bus_req = 0;
        step();
        chk(bus_addr_en == 0, "R9 idle after release", bus_addr_en, 0);
        step();
        chk(bus_addr_en == 1 && bus_addr == 16'hBEEF, "R9 cpu runs", bus_addr, 16'hBEEF);
        step(); bus_ready_n = 0;
        step(); bus_ready_n = 1;
        step();
    endtask

    task automatic t_req_while_lent();
        dev_bus_req = 1;
        step();
        cpu_req_valid = 1; cpu_req_write = 1; cpu_req_addr = 16'h4321; cpu_req_wdata = 32'h0000_00FF;
        step(); cpu_req_valid = 0;
        chk(cpu_req_ready == 0, "R10 taken while lent", cpu_req_ready, 0);
        step();
        chk(bus_addr_en == 0, "R10 held off", bus_addr_en, 0);
        dev_bus_req = 0;
        step();
        chk(dev_bus_grant == 0 && bus_addr_en == 0, "R10 release idle", bus_addr_en, 0);
        step();
        chk(bus_addr_en == 1 && bus_addr == 16'h4321, "R10 starts after release", bus_addr, 16'h4321);
        step(); bus_ready_n = 0;
        step(); bus_ready_n = 1;
        chk(cpu_done == 1, "R10 completes", cpu_done, 1);
        step();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        t_reset();
        t_read();
        t_write();
        t_grant();
        t_req_mid_transfer();
        t_same_cycle();
        t_req_while_lent();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
        finish_run();
    end
endmodule